// File: doc/BRIEF.md
# All-Digital Continuous-Phase MSK Modulator

This block turns a serial bit stream into a one-bit square-wave minimum-shift-keyed signal. It needs only the system clock: no analog carrier source and no sine table. A two-stage prescaler divides the clock down to a tick. A symbol timer counts a fixed number of ticks per bit. Two carrier dividers run off the tick and produce a square wave for each symbol value. A "1" symbol carries exactly two carrier cycles and a "0" symbol carries two and a half, which gives a modulation index of 0.5.

A one-bit phase register keeps the waveform continuous across symbol boundaries. A "0" symbol stops in the middle of a carrier cycle, so the phase bit flips after every "0" and holds after every "1". The selected carrier is XORed with that phase bit and registered onto the output. At the end of each symbol the block raises a one-clock request strobe. The source presents the next bit on `data_in`, and that bit is taken on the clock edge where the strobe is high.

Top module: `msk_modulator`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `mod_out` is 0 and `bit_req` is 0.
- R2: One tick occurs every PRE_DIV1*PRE_DIV2 clocks and one symbol lasts SYM_TICKS ticks (80 clocks by default). `bit_req` is high for exactly one clock per symbol, in the clock of the symbol's last tick.
- R3: `data_in` is sampled on the rising edge at which `bit_req` is high, and that bit is sent in the following symbol. The first symbol after reset sends a "0" bit.
- R4: A "1" symbol (data bit value 1) uses a carrier with a period of SYM_TICKS/2 ticks (10 by default). Before the phase is applied, the carrier is low for the first half of the period and high for the second half, so the symbol spans two full cycles.
- R5: A "0" symbol (data bit value 0) uses a carrier with a period of 2*SYM_TICKS/5 ticks (8 by default), with the same low-then-high shape, so the symbol spans 2.5 cycles.
- R6: The output equals the selected carrier XOR a phase bit. The phase bit is 0 after reset, inverts after every "0" symbol and holds after every "1" symbol. As a result every output run between level changes lasts exactly half a carrier period (4 or 5 ticks), including across symbol boundaries.
- R7: `mod_out` is registered. It changes only on the clock after a tick has advanced the carrier counters, so every run length is a whole number of tick periods.
- R8: Both carrier dividers restart at count 0 at every symbol boundary. Each symbol therefore begins at the start of the low half of its carrier, before the phase is applied.
- R9: Values on `data_in` in clocks where `bit_req` is low have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | Next data bit, taken when `bit_req` is high |
| bit_req | output | 1 | One-clock strobe on the last tick of each symbol |
| mod_out | output | 1 | Registered MSK square-wave output |

## Verification
The situation hardest to reach from the ports is a boundary where the phase bit has already been flipped by an earlier "0". The check there is whether the next symbol starts on the inverted level, and this can only be seen as a run length across the boundary. The stimulus runs fixed sequences with doubled and tripled zeros and ones, then pseudo-random bits. The bench measures every output run in clocks. Garbage is toggled on `data_in` inside every symbol to show that only the strobed edge matters.

// File: rtl/msk_pkg.sv
package msk_pkg;
  localparam int NUM_SYMBOLS = 2;

  typedef enum logic {
    SYM_ZERO = 1'b0,
    SYM_ONE  = 1'b1
  } msk_sym_e;

  // carrier period in ticks for a symbol value, given the symbol length
  function automatic int carrier_period(input int sym, input int sym_ticks);
    if (sym == 1) return sym_ticks / 2;
    return (sym_ticks * 2) / 5;
  endfunction
endpackage

// File: rtl/msk_prescaler.sv
module msk_prescaler #(
  parameter int DIV1 = 2,
  parameter int DIV2 = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o,
  output logic tick_next_o
);
  localparam int W1 = (DIV1 > 1) ? $clog2(DIV1) : 1;
  localparam int W2 = (DIV2 > 1) ? $clog2(DIV2) : 1;
  localparam logic [W1-1:0] LAST1 = W1'(DIV1 - 1);
  localparam logic [W2-1:0] LAST2 = W2'(DIV2 - 1);

  logic [W1-1:0] cnt1_q, cnt1_n;
  logic [W2-1:0] cnt2_q, cnt2_n;
  logic          wrap1;

  always_comb begin
    wrap1  = (cnt1_q == LAST1);
    cnt1_n = wrap1 ? '0 : cnt1_q + 1'b1;
    cnt2_n = cnt2_q;
    if (wrap1) cnt2_n = (cnt2_q == LAST2) ? '0 : cnt2_q + 1'b1;
  end

  assign tick_o      = wrap1 && (cnt2_q == LAST2);
  assign tick_next_o = (cnt1_n == LAST1) && (cnt2_n == LAST2);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt1_q <= '0;
      cnt2_q <= '0;
    end else begin
      cnt1_q <= cnt1_n;
      cnt2_q <= cnt2_n;
    end
  end
endmodule

// File: rtl/msk_symbol_timer.sv
module msk_symbol_timer #(
  parameter int SYM_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic tick_next_i,
  output logic boundary_o,
  output logic boundary_next_o
);
  localparam int SW = $clog2(SYM_TICKS);
  localparam logic [SW-1:0] SYM_LAST = SW'(SYM_TICKS - 1);

  logic [SW-1:0] pos_q, pos_n;

  always_comb begin
    boundary_o = tick_i && (pos_q == SYM_LAST);
    pos_n      = pos_q;
    if (tick_i) pos_n = boundary_o ? '0 : pos_q + 1'b1;
    boundary_next_o = tick_next_i && (pos_n == SYM_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) pos_q <= '0;
    else     pos_q <= pos_n;
  end
endmodule

// File: rtl/msk_carrier_div.sv
module msk_carrier_div #(
  parameter int PERIOD = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic restart_i,
  output logic wave_o
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] CNT_LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(PERIOD / 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i)  cnt_q <= '0;
    else if (tick_i)       cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
  end

  // low for the first half of the period, high for the second
  assign wave_o = (cnt_q >= CNT_HALF);
endmodule

// File: rtl/msk_modulator.sv
module msk_modulator #(
  parameter int PRE_DIV1  = 2,
  parameter int PRE_DIV2  = 2,
  parameter int SYM_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic data_in,
  output logic bit_req,
  output logic mod_out
);
  import msk_pkg::*;

  logic tick, tick_next;
  logic boundary, boundary_next;
  logic [NUM_SYMBOLS-1:0] wave;
  msk_sym_e data_q;
  logic phase_q;
  logic bit_req_q, mod_q;

  msk_prescaler #(.DIV1(PRE_DIV1), .DIV2(PRE_DIV2)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick), .tick_next_o(tick_next)
  );

  msk_symbol_timer #(.SYM_TICKS(SYM_TICKS)) u_sym (
    .clk(clk), .rst(rst), .tick_i(tick), .tick_next_i(tick_next),
    .boundary_o(boundary), .boundary_next_o(boundary_next)
  );

  for (genvar g = 0; g < NUM_SYMBOLS; g++) begin : g_carrier
    msk_carrier_div #(.PERIOD(carrier_period(g, SYM_TICKS))) u_div (
      .clk(clk), .rst(rst), .tick_i(tick), .restart_i(boundary),
      .wave_o(wave[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= SYM_ZERO;
      phase_q   <= 1'b0;
      bit_req_q <= 1'b0;
      mod_q     <= 1'b0;
    end else begin
      bit_req_q <= boundary_next;
      mod_q     <= wave[data_q] ^ phase_q;
      if (boundary) begin
        data_q <= msk_sym_e'(data_in);
        // a "0" symbol ends half way through a carrier cycle
        if (data_q == SYM_ZERO) phase_q <= ~phase_q;
      end
    end
  end

  assign bit_req = bit_req_q;
  assign mod_out = mod_q;
endmodule

// File: rtl/msk_modulator_chk.sv
module msk_modulator_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic boundary,
  input logic data_q,
  input logic phase,
  input logic mod_o,
  input logic bit_req
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!mod_o && !bit_req)); // R1
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst) bit_req |=> !bit_req); // R2
  AST_REQ_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst) bit_req |-> boundary); // R3
  AST_PHASE_FLIP_ZERO: assert property (@(posedge clk) disable iff (rst) (boundary && !data_q) |=> (phase != $past(phase))); // R6
  AST_PHASE_KEEP_ONE: assert property (@(posedge clk) disable iff (rst) (boundary && data_q) |=> $stable(phase)); // R6
  AST_MIDSYM_STABLE: assert property (@(posedge clk) disable iff (rst) !boundary |=> ($stable(phase) && $stable(data_q))); // R9
  AST_OUT_AFTER_TICK: assert property (@(posedge clk) disable iff (rst) (mod_o != $past(mod_o)) |-> $past(tick, 2)); // R7
endmodule

bind msk_modulator msk_modulator_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .boundary(boundary),
  .data_q(data_q), .phase(phase_q), .mod_o(mod_out), .bit_req(bit_req)
);

// File: tb/msk_modulator_test.sv
module msk_modulator_test;
  localparam int CLK_PERIOD = 10;
  localparam int D1 = 2;
  localparam int D2 = 2;
  localparam int SYM = 20;
  localparam int P = D1 * D2;
  localparam int NBITS = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_in = 1'b0;
  logic bit_req, mod_out;

  int checks = 0;
  int errors = 0;

  msk_modulator #(.PRE_DIV1(D1), .PRE_DIV2(D2), .SYM_TICKS(SYM)) uut (
    .clk(clk), .rst(rst), .data_in(data_in), .bit_req(bit_req), .mod_out(mod_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  // behavioural reference: clock phase within tick, tick within symbol
  int  m_pc = 0, m_s = 0, m_symidx = 0, m_bounds = 0;
  logic m_cur = 1'b0, m_ph = 1'b0, m_mod = 1'b0;
  int  seen_req = 0;

  function automatic logic carrier(input logic b, input int s);
    if (b) return (s % (SYM/2)) >= (SYM/4);
    return (s % (SYM*2/5)) >= (SYM/5);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pc = 0; m_s = 0; m_cur = 1'b0; m_ph = 1'b0; m_mod = 1'b0;
      m_symidx = 0; m_bounds = 0;
    end else begin
      m_mod = carrier(m_cur, m_s) ^ m_ph;
      if (m_pc == P-1) begin
        m_pc = 0;
        if (m_s == SYM-1) begin
          m_s = 0;
          if (!m_cur) m_ph = ~m_ph;
          m_cur = data_in;
          m_symidx++;
          m_bounds++;
        end else m_s++;
      end else m_pc++;
    end
  end

  // per-clock comparison with requirement tags
  logic prev_mod = 1'b0;
  int   run_len = 0, runs = 0;
  bit   compare_on = 1'b0;

  always @(negedge clk) begin
    if (compare_on && !rst) begin
      check("R2", bit_req, (m_pc == P-1 && m_s == SYM-1));
      if (bit_req) seen_req++;
      if (m_symidx == 0) check("R3", mod_out, m_mod);
      else if (m_s < 4) check("R8/R9", mod_out, m_mod);
      else if (m_cur) check("R4/R9", mod_out, m_mod);
      else check("R5/R9", mod_out, m_mod);
      if (mod_out != prev_mod) begin
        if (runs >= 1) begin
          check("R6", ((run_len == 4*P) || (run_len == 5*P)) ? 1 : 0, 1);
          check("R7", run_len % P, 0);
        end
        runs++;
        run_len = 1;
      end else run_len++;
      prev_mod = mod_out;
    end
  end

  logic bits [NBITS];

  initial begin
    logic [7:0] lf;
    lf = 8'hA5;
    bits[0] = 1; bits[1] = 1; bits[2] = 0; bits[3] = 0; bits[4] = 1; bits[5] = 0;
    bits[6] = 1; bits[7] = 1; bits[8] = 1; bits[9] = 0; bits[10] = 0; bits[11] = 0;
    for (int i = 12; i < NBITS; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      bits[i] = lf[0];
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", mod_out, 0);
    check("R1", bit_req, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", mod_out, 0);
    check("R1", bit_req, 0);
    compare_on = 1'b1;

    for (int i = 0; i < NBITS; i++) begin
      while (!bit_req) begin
        @(negedge clk);
        data_in = ~data_in;   // mid-symbol garbage, must be ignored
      end
      data_in = bits[i];
      @(negedge clk);
      data_in = ~bits[i];
    end
    repeat (3*SYM*P) @(negedge clk);
    check("R2", seen_req, m_bounds);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule